// File: doc/BRIEF.md
# I2C Master SCL Clock Generator

This block produces the serial clock of an I2C master by dividing the system clock. It has no analog part, so the bit rate is as accurate as the system clock. A timer-period value sets the rate. SCL is driven open-drain style: the block either pulls the line low or lets it go. It reads the line back through a two-flop synchronizer and an optional glitch filter.

Each bit period has two parts:

- **Low phase:** a fixed count of system clocks, during which the block pulls SCL low.
- **High phase:** after releasing the line, the block waits until the sensed SCL reads high. Only then does it count a fixed high phase, and after that it pulls the line low again.

A slow pull-up rise and a target holding SCL low both delay the moment SCL is sensed high. The block cannot tell these apart, and either one lengthens the period.

A one-cycle strobe marks each falling edge the block generates. The byte engine uses it to change SDA during the low phase.

With a 250 MHz bench clock the numbers are only relative. With a 120 MHz system clock, a period value of 5 gives about 1 Mbit/s and a value of 14 gives about 400 kbit/s.

Top module: `i2c_scl_gen`

## Requirements
- R1: While reset is asserted or `en_i` is low, `scl_pull_o` is 0 (line released) and `fall_stb_o` is 0. Enabling again always begins with a full low phase.
- R2: Each low phase holds `scl_pull_o` at 1 for exactly 12*(1+`period_i`) clock cycles, whatever the line does.
- R3: After the release, the high-phase count does not start until the filtered SCL sample reads high. The released time is 8*(1+`period_i`) + 3 + `filt_i` + D cycles, where D is the number of cycles from release until `scl_i` reads 1.
- R4: Once SCL is sensed high, the block pulls the line low again after exactly 8*(1+`period_i`) cycles.
- R5: `fall_stb_o` is 1 for exactly one cycle, in the first cycle of every low phase, and at no other time.
- R6: With `filt_i` = 0 the filter is bypassed. The detection latency is then 3 cycles: two synchronizer stages plus the phase register.
- R7: With `filt_i` = F > 0, a new SCL level is accepted only after it has been sampled on F consecutive cycles. A high pulse shorter than F cycles does not end the wait, and an accepted level adds F cycles.
- R8: When `en_i` rises while the block is idle, `scl_pull_o` and `fall_stb_o` are 1 in the next cycle.
- R9: A target holding SCL low for D cycles lengthens the released time in exactly the same way as a rise delay of D cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| en_i | input | 1 | Run enable; when low the block releases the line and clears its counters |
| period_i | input | PER_W (7) | Timer-period value; change it only while disabled |
| filt_i | input | FILT_W (4) | Glitch-filter width in cycles; 0 bypasses the filter |
| scl_i | input | 1 | Sensed SCL pin level |
| scl_pull_o | output | 1 | 1 pulls SCL low, 0 releases it |
| fall_stb_o | output | 1 | One-cycle strobe at each generated falling edge |

## Verification
The assertions check four behaviours on every cycle:

- the line is released whenever the block is disabled;
- the strobe is a single cycle and coincides exactly with the start of each pull;
- every completed low phase has the length set by the period value;
- the block never pulls the line while it waits and has not yet sensed SCL high.

Only the bench scenarios can show the released-time arithmetic, because it depends on the external line. These scenarios cover rise delays, long target stretching, filter latency and rejection of short high glitches, and the extreme period values. A line model in the bench produces each of these conditions.

// File: rtl/scl_pkg.sv
package scl_pkg;
  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_LOW  = 2'd1,
    PH_WAIT = 2'd2,
    PH_HIGH = 2'd3
  } phase_e;

  localparam int LOW_UNITS  = 6;
  localparam int HIGH_UNITS = 4;
endpackage

// File: rtl/scl_sync.sv
module scl_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], d_i};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) chain_q <= '1;
    else         chain_q <= chain_d;
  end

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/scl_filter.sv
module scl_filter #(
  parameter int FILT_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [FILT_W-1:0] width_i,
  input  logic              d_i,
  output logic              q_o
);
  logic              lvl_q, lvl_d;
  logic [FILT_W-1:0] run_q, run_d;
  logic              bypass;

  assign bypass = (width_i == '0);

  always_comb begin
    lvl_d = lvl_q;
    run_d = run_q;
    if (bypass) begin
      lvl_d = d_i;
      run_d = '0;
    end else if (d_i == lvl_q) begin
      run_d = '0;
    end else if (run_q == width_i - 1'b1) begin
      lvl_d = d_i;
      run_d = '0;
    end else begin
      run_d = run_q + 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lvl_q <= 1'b1;
      run_q <= '0;
    end else begin
      lvl_q <= lvl_d;
      run_q <= run_d;
    end
  end

  assign q_o = bypass ? d_i : lvl_q;
endmodule

// File: rtl/scl_phase_ctrl.sv
module scl_phase_ctrl
  import scl_pkg::*;
#(
  parameter int PER_W = 7,
  parameter int CNT_W = 11
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic [PER_W-1:0] period_i,
  input  logic             scl_hi_i,
  output logic             pull_o,
  output logic             stb_o,
  output phase_e           phase_o
);
  phase_e           ph_q, ph_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             pull_q, pull_d;
  logic             stb_q, stb_d;
  logic [CNT_W-1:0] low_len, high_len;

  // Phase lengths scale with (1 + period): the low and high shares of the bit.
  assign low_len  = CNT_W'((32'(period_i) + 32'd1) * 32'(2 * LOW_UNITS));
  assign high_len = CNT_W'((32'(period_i) + 32'd1) * 32'(2 * HIGH_UNITS));

  always_comb begin
    ph_d  = ph_q;
    cnt_d = cnt_q;
    if (!en_i) begin
      ph_d  = PH_IDLE;
      cnt_d = '0;
    end else begin
      unique case (ph_q)
        PH_IDLE: begin
          ph_d  = PH_LOW;
          cnt_d = '0;
        end
        PH_LOW: begin
          if (cnt_q == low_len - 1'b1) begin
            ph_d  = PH_WAIT;
            cnt_d = '0;
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
        PH_WAIT: begin
          // High timing starts only once the line is sensed high.
          if (scl_hi_i) begin
            ph_d  = PH_HIGH;
            cnt_d = '0;
          end
        end
        PH_HIGH: begin
          if (cnt_q == high_len - 1'b1) begin
            ph_d  = PH_LOW;
            cnt_d = '0;
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
        default: begin
          ph_d  = PH_IDLE;
          cnt_d = '0;
        end
      endcase
    end
    pull_d = (ph_d == PH_LOW);
    stb_d  = (ph_d == PH_LOW) && (ph_q != PH_LOW);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ph_q   <= PH_IDLE;
      cnt_q  <= '0;
      pull_q <= 1'b0;
      stb_q  <= 1'b0;
    end else begin
      ph_q   <= ph_d;
      cnt_q  <= cnt_d;
      pull_q <= pull_d;
      stb_q  <= stb_d;
    end
  end

  assign pull_o  = pull_q;
  assign stb_o   = stb_q;
  assign phase_o = ph_q;
endmodule

// File: rtl/i2c_scl_gen.sv
module i2c_scl_gen
  import scl_pkg::*;
#(
  parameter int PER_W  = 7,
  parameter int FILT_W = 4,
  parameter int SYNC_N = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic [PER_W-1:0]  period_i,
  input  logic [FILT_W-1:0] filt_i,
  input  logic              scl_i,
  output logic              scl_pull_o,
  output logic              fall_stb_o
);
  localparam int MAX_LEN = 2 * LOW_UNITS * (1 << PER_W);
  localparam int CNT_W   = $clog2(MAX_LEN + 1);

  logic   scl_sync;
  logic   scl_hi;
  phase_e phase;

  scl_sync #(.STAGES(SYNC_N)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (scl_i),
    .q_o    (scl_sync)
  );

  scl_filter #(.FILT_W(FILT_W)) u_filt (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .width_i (filt_i),
    .d_i     (scl_sync),
    .q_o     (scl_hi)
  );

  scl_phase_ctrl #(.PER_W(PER_W), .CNT_W(CNT_W)) u_phase (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .en_i     (en_i),
    .period_i (period_i),
    .scl_hi_i (scl_hi),
    .pull_o   (scl_pull_o),
    .stb_o    (fall_stb_o),
    .phase_o  (phase)
  );
endmodule

// File: rtl/i2c_scl_gen_chk.sv
module i2c_scl_gen_chk
  import scl_pkg::*;
#(
  parameter int PER_W = 7
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             en_i,
  input logic [PER_W-1:0] period_i,
  input logic             scl_pull_o,
  input logic             fall_stb_o,
  input logic             scl_hi,
  input phase_e           phase
);
  int unsigned pull_run;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         pull_run <= 0;
    else if (scl_pull_o) pull_run <= pull_run + 1;
    else                 pull_run <= 0;
  end

  // R1
  a_r1_release_when_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (!scl_pull_o && !fall_stb_o));

  // R2
  a_r2_low_len: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(scl_pull_o) && $past(en_i)) |->
      (pull_run == (32'(period_i) + 1) * 12));

  // R3
  a_r3_hold_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && phase == PH_WAIT && !scl_hi) |=> !scl_pull_o);

  // R5
  a_r5_strobe_at_fall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fall_stb_o |-> $rose(scl_pull_o));

  // R5
  a_r5_fall_has_strobe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(scl_pull_o) |-> fall_stb_o);

  // R5
  a_r5_strobe_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fall_stb_o |=> !fall_stb_o);
endmodule

bind i2c_scl_gen i2c_scl_gen_chk #(.PER_W(PER_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .en_i       (en_i),
  .period_i   (period_i),
  .scl_pull_o (scl_pull_o),
  .fall_stb_o (fall_stb_o),
  .scl_hi     (scl_hi),
  .phase      (phase)
);

// File: tb/i2c_scl_gen_tb.sv
module i2c_scl_gen_tb;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       en;
  logic [6:0] period;
  logic [3:0] filt;
  logic       scl_line;
  logic       pull;
  logic       stb;

  int errors = 0;
  int checks = 0;
  int cyc    = 0;

  int delay_d  = 0;
  bit glitch   = 1'b0;
  int rel_cnt  = 0;

  int exp_low[$];
  int exp_rel[$];
  string exp_tag[$];

  always #2 clk = ~clk;

  i2c_scl_gen u_dut (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .en_i       (en),
    .period_i   (period),
    .filt_i     (filt),
    .scl_i      (scl_line),
    .scl_pull_o (pull),
    .fall_stb_o (stb)
  );

  // Line model: open drain with a rise delay (or target hold) of delay_d
  // cycles, plus an optional two-cycle high glitch inside that window.
  always @(posedge clk) begin
    if (pull)                rel_cnt <= 0;
    else if (rel_cnt < 100000) rel_cnt <= rel_cnt + 1;
  end
  assign scl_line = !pull && ((rel_cnt >= delay_d) ||
                              (glitch && rel_cnt >= 3 && rel_cnt < 5));

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 190000) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=%0d expected<=190000 cycles", cyc);
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  // Monitor: measures pull and release widths, pops expected items.
  bit prev_pull = 1'b0;
  bit seen_low  = 1'b0;
  int low_w = 0;
  int rel_w = 0;
  always @(negedge clk) begin
    if (!rst_n || !en) begin
      prev_pull = 1'b0;
      seen_low  = 1'b0;
      low_w = 0;
      rel_w = 0;
    end else begin
      if (pull && !prev_pull) begin
        check(stb == 1'b1, "R5 strobe at fall", int'(stb), 1);
        if (seen_low && exp_low.size() > 0) begin
          string t;
          int el, er;
          t  = exp_tag.pop_front();
          el = exp_low.pop_front();
          er = exp_rel.pop_front();
          check(low_w == el, {"R2 low width ", t}, low_w, el);
          check(rel_w == er, {"R3 release width ", t}, rel_w, er);
        end
        low_w = 1;
      end else if (pull) begin
        low_w++;
        if (stb) begin
          errors++;
          $display("FAIL R5 strobe extra actual=1 expected=0");
        end
      end else begin
        if (prev_pull) begin
          seen_low = 1'b1;
          rel_w = 1;
        end else begin
          rel_w++;
        end
        if (stb) begin
          errors++;
          $display("FAIL R5 strobe while released actual=1 expected=0");
        end
      end
      prev_pull = pull;
    end
  end

  task automatic run_case(input int p, input int f, input int d, input bit g,
                          input int n, input string tag);
    @(negedge clk);
    en = 1'b0;
    period = 7'(p);
    filt = 4'(f);
    delay_d = d;
    glitch = g;
    repeat (3) @(negedge clk);
    for (int i = 0; i < n; i++) begin
      exp_low.push_back(12 * (1 + p));
      exp_rel.push_back(8 * (1 + p) + 3 + f + d);
      exp_tag.push_back(tag);
    end
    en = 1'b1;
    @(negedge clk);
    check(pull == 1'b1 && stb == 1'b1, {"R8 start after enable ", tag}, int'(pull), 1);
    wait (exp_low.size() == 0);
    @(negedge clk);
    en = 1'b0;
  endtask

  initial begin
    rst_n = 1'b0;
    en = 1'b0;
    period = 7'd5;
    filt = 4'd0;
    repeat (4) @(negedge clk);
    check(pull == 1'b0 && stb == 1'b0, "R1 reset releases line", int'(pull), 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check(pull == 1'b0, "R1 idle while disabled", int'(pull), 0);

    // R6: filter bypassed, three-cycle detection latency
    run_case(5, 0, 0, 1'b0, 3, "R6 p5 no filter");
    run_case(14, 0, 0, 1'b0, 2, "R4 p14");
    // R3: rise delay extends the released time
    run_case(5, 0, 4, 1'b0, 2, "R3 rise 4");
    // R9: long target hold behaves like a long rise
    run_case(5, 0, 40, 1'b0, 2, "R9 hold 40");
    run_case(0, 0, 0, 1'b0, 3, "R2 p0 min");
    // R7: filter of 3 rejects a 2-cycle glitch, adds 3 cycles
    run_case(2, 3, 10, 1'b1, 3, "R7 filt3 glitch");
    run_case(127, 0, 0, 1'b0, 2, "R2 p127 max");

    // R1: disable in the middle of a low phase
    @(negedge clk);
    period = 7'd5;
    filt = 4'd0;
    delay_d = 0;
    glitch = 1'b0;
    en = 1'b1;
    repeat (10) @(negedge clk);
    en = 1'b0;
    @(negedge clk);
    check(pull == 1'b0 && stb == 1'b0, "R1 release on disable", int'(pull), 0);
    begin
      int pulls = 0;
      for (int i = 0; i < 30; i++) begin
        @(negedge clk);
        if (pull || stb) pulls++;
      end
      check(pulls == 0, "R1 stays released while disabled", pulls, 0);
    end
    // R1: re-enable begins with a full low phase
    run_case(5, 0, 0, 1'b0, 1, "R1 restart full low");

    repeat (5) @(negedge clk);
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule